// File: doc/BRIEF.md
# USB Data-Packet CRC16 Checker

This block checks the 16-bit CRC that protects the payload of a USB data packet. The receive path feeds it the bytes that follow the packet identifier, one byte per accepted beat. This includes the two CRC bytes the sender appended. A start pulse opens each packet and an end pulse closes it. On the cycle after the end pulse, the block reports for one cycle whether the packet is good, together with the final value of its CRC register.

The register runs in reflected, least-significant-bit-first form. It shifts right with feedback constant 0xA001 and is seeded with 0xFFFF. Each byte is applied one beat late: a byte is held for a beat and folded in while the next byte arrives. At end of packet, the held byte and any byte arriving in that same beat are folded in combinationally. The result is therefore identical to a direct computation.

A packet is judged good when the absorbed stream leaves the fixed residue 0xB001 in the register. No separately received CRC field is compared. The input is a valid/ready byte stream with no back-pressure. `in_ready` is always high, so every cycle with `in_valid` high transfers a byte, and `in_data` is ignored when `in_valid` is low.

Top module: `usb_crc16_check`

## Requirements
- R1: The register uses feedback constant 0xA001, shifts right with data least-significant bit first, and starts at 0xFFFF. The nine bytes 0x31..0x39 give `res_crc` = 0x4B37.
- R2: `pkt_start` reloads the register with 0xFFFF and discards all earlier bytes. A packet with no bytes reports `res_crc` = 0xFFFF.
- R3: `res_valid` is high for exactly one cycle, the cycle after each `pkt_end` beat, and is low at all other times.
- R4: `res_pass` is 1 only when the final register equals 0xB001 and at least two bytes were absorbed. A payload followed by its inverted CRC (low byte first) passes, and a payload with any flipped bit fails.
- R5: A packet with fewer than two bytes reports `res_pass` = 0. A packet of exactly two bytes that leaves the residue passes.
- R6: A byte presented with `in_valid` in the same beat as `pkt_end` is included in the result.
- R7: `in_ready` is always 1. Beats with `in_valid` low change nothing, whatever `in_data` holds.
- R8: After reset, `res_valid` = 0, `res_pass` = 0 and `res_crc` = 0xFFFF.
- R9: A byte presented with `in_valid` in the same beat as `pkt_start` is the first byte of the new packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pkt_start | input | 1 | Opens a new packet; reloads the register |
| in_valid | input | 1 | Byte beat valid |
| in_ready | output | 1 | Always 1; the block never stalls |
| in_data | input | 8 | Byte following the packet identifier |
| pkt_end | input | 1 | Closes the packet |
| res_valid | output | 1 | One-cycle result strobe |
| res_pass | output | 1 | 1 when the packet CRC is correct |
| res_crc | output | 16 | Final register value |

## Verification
All three result outputs are registered together on the clock edge that sees `pkt_end`, so they are due exactly one cycle after the end beat. The bench changes inputs on falling edges and reads the results on the falling edge that follows the end beat. It then reads `res_valid` again one falling edge later to confirm that it has dropped. Expected CRC values come from a bit-serial model in the bench, not from any byte table. The merged start and end beats of R6 and R9 use the same one-cycle sampling point.

// File: rtl/usb_crc16_pkg.sv
package usb_crc16_pkg;
  localparam int          CRC_W    = 16;
  localparam int          BYTE_W   = 8;
  localparam logic [15:0] CRC_POLY = 16'hA001;
  localparam logic [15:0] CRC_INIT = 16'hFFFF;
  localparam logic [15:0] CRC_GOOD = 16'hB001;
  localparam int          MIN_LEN  = 2;
endpackage

// File: rtl/usb_crc16_step.sv
// One byte of reflected CRC update, unrolled into DW shift stages.
module usb_crc16_step #(
  parameter int             CW   = 16,
  parameter int             DW   = 8,
  parameter logic [CW-1:0]  POLY = 16'hA001
) (
  input  logic [CW-1:0] crc_in,
  input  logic [DW-1:0] data_in,
  output logic [CW-1:0] crc_out
);
  logic [CW-1:0] stage [0:DW];

  assign stage[0] = crc_in ^ {{(CW-DW){1'b0}}, data_in};

  generate
    for (genvar i = 0; i < DW; i++) begin : g_shift
      assign stage[i+1] = (stage[i] >> 1) ^ (stage[i][0] ? POLY : '0);
    end
  endgenerate

  assign crc_out = stage[DW];

  // R1: a zero table index leaves only the old high part shifted down
  always_comb begin
    if ((crc_in[DW-1:0] ^ data_in) == '0) begin
      zero_index_chk: assert (crc_out == (crc_in >> DW));
    end
  end
endmodule

// File: rtl/usb_crc16_accum.sv
// Holds the register and a one-beat-late pending byte; exposes the folded
// value that includes the pending byte and the current beat.
module usb_crc16_accum
  import usb_crc16_pkg::*;
#(
  parameter int MIN_BYTES = MIN_LEN,
  localparam int NW = $clog2(MIN_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [CRC_W-1:0]  fold_crc,
  output logic [NW-1:0]     fold_cnt
);
  logic [CRC_W-1:0]  crc_q;
  logic [BYTE_W-1:0] pend_q;
  logic              pend_vld_q;
  logic [NW-1:0]     cnt_q;

  logic [CRC_W-1:0]  late_out, base, eff_base, cur_out;
  logic [NW-1:0]     eff_cnt;

  usb_crc16_step #(.CW(CRC_W), .DW(BYTE_W), .POLY(CRC_POLY)) u_late (
    .crc_in(crc_q), .data_in(pend_q), .crc_out(late_out));

  assign base     = pend_vld_q ? late_out : crc_q;
  assign eff_base = start ? CRC_INIT : base;
  assign eff_cnt  = start ? '0 : cnt_q;

  usb_crc16_step #(.CW(CRC_W), .DW(BYTE_W), .POLY(CRC_POLY)) u_now (
    .crc_in(eff_base), .data_in(byte_in), .crc_out(cur_out));

  assign fold_crc = byte_vld ? cur_out : eff_base;

  always_comb begin
    fold_cnt = eff_cnt;
    if (byte_vld && eff_cnt != NW'(MIN_BYTES)) fold_cnt = eff_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q      <= CRC_INIT;
      pend_q     <= '0;
      pend_vld_q <= 1'b0;
      cnt_q      <= '0;
    end else if (start || byte_vld) begin
      crc_q      <= eff_base;
      pend_q     <= byte_in;
      pend_vld_q <= byte_vld;
      cnt_q      <= fold_cnt;
    end
  end

  // R2: a bare start leaves a fresh register and no pending byte
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !byte_vld |=> crc_q == CRC_INIT && !pend_vld_q && cnt_q == '0);

  // R5: byte count saturates at the minimum length
  count_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= NW'(MIN_BYTES));

  // R7: idle beats leave the state untouched
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start && !byte_vld |=> $stable(crc_q) && $stable(cnt_q) && $stable(pend_vld_q));
endmodule

// File: rtl/usb_crc16_check.sv
module usb_crc16_check
  import usb_crc16_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pkt_start,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic        pkt_end,
  output logic        res_valid,
  output logic        res_pass,
  output logic [15:0] res_crc
);
  localparam int NW = $clog2(MIN_LEN + 1);

  logic [CRC_W-1:0] fold_crc;
  logic [NW-1:0]    fold_cnt;

  assign in_ready = 1'b1;

  usb_crc16_accum #(.MIN_BYTES(MIN_LEN)) u_acc (
    .clk(clk), .rst_n(rst_n), .start(pkt_start), .byte_vld(in_valid),
    .byte_in(in_data), .fold_crc(fold_crc), .fold_cnt(fold_cnt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_pass  <= 1'b0;
      res_crc   <= CRC_INIT;
    end else begin
      res_valid <= pkt_end;
      if (pkt_end) begin
        res_crc  <= fold_crc;
        res_pass <= (fold_crc == CRC_GOOD) && (fold_cnt == NW'(MIN_LEN));
      end else begin
        res_pass <= 1'b0;
      end
    end
  end

  // R3
  end_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |=> res_valid);
  // R3
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_end |=> !res_valid);
  // R4
  pass_residue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_pass |-> res_valid && res_crc == CRC_GOOD);
  // R5
  short_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end && fold_cnt != NW'(MIN_LEN) |=> !res_pass);
endmodule

// File: tb/sim_usb_crc16_check.sv
module sim_usb_crc16_check;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {n[3:0], 6 payload bytes, append_crc, corrupt, start_merge, end_merge}
  localparam logic [55:0] VECS [0:NVEC-1] = '{
    {4'd3, 48'h010203000000, 4'b1000},
    {4'd3, 48'h010203000000, 4'b1100},
    {4'd1, 48'h000000000000, 4'b0000},
    {4'd0, 48'h000000000000, 4'b0000},
    {4'd6, 48'hDEADBEEF1234, 4'b1001},
    {4'd2, 48'h80FF00000000, 4'b1010},
    {4'd0, 48'h000000000000, 4'b1000},
    {4'd5, 48'h0F1E2D3C4B00, 4'b1011}
  };

  logic clk = 0, rst_n = 0;
  logic pkt_start = 0, in_valid = 0, pkt_end = 0;
  logic [7:0] in_data = 0;
  logic in_ready, res_valid, res_pass;
  logic [15:0] res_crc;

  int tests = 0, fails = 0;
  logic [7:0] pbuf [0:15];
  int plen;

  usb_crc16_check u0 (.clk(clk), .rst_n(rst_n), .pkt_start(pkt_start),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .pkt_end(pkt_end), .res_valid(res_valid), .res_pass(res_pass),
    .res_crc(res_crc));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] ref_crc(input int len);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < len; i++)
      for (int b = 0; b < 8; b++) begin
        logic fb = c[0] ^ pbuf[i][b];
        c = c >> 1;
        if (fb) c = c ^ 16'hA001;
      end
    return c;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic run_pkt(input bit smerge, input bit emerge, input bit gaps,
                         input string rq);
    logic [15:0] ec = ref_crc(plen);
    bit ep = (ec == 16'hB001) && (plen >= 2);
    bit sm = smerge && plen > 0;
    bit em = emerge && plen > 0;
    if (!sm) begin
      pkt_start = 1; @(negedge clk); pkt_start = 0;
    end
    for (int i = 0; i < plen; i++) begin
      if (sm && i == 0) pkt_start = 1;
      in_valid = 1; in_data = pbuf[i];
      if (em && i == plen-1) pkt_end = 1;
      @(negedge clk);
      pkt_start = 0; in_valid = 0; pkt_end = 0; in_data = 8'hC3;
      if (gaps && i != plen-1) begin
        in_data = 8'h5A ^ 8'(i); @(negedge clk);
      end
    end
    if (!em) begin
      pkt_end = 1; in_data = 8'h3C; @(negedge clk); pkt_end = 0;
    end
    chk(res_valid == 1'b1, "R3", "res_valid after end", 32'(res_valid), 32'd1);
    chk(res_crc == ec, rq, "res_crc", 32'(res_crc), 32'(ec));
    chk(res_pass == ep, rq, "res_pass", 32'(res_pass), 32'(ep));
    @(negedge clk);
    chk(res_valid == 1'b0, "R3", "res_valid one cycle", 32'(res_valid), 32'd0);
  endtask

  task automatic load_vec(input logic [55:0] v);
    logic [15:0] c;
    plen = int'(v[55:52]);
    for (int i = 0; i < 6; i++) pbuf[i] = v[51 - 8*i -: 8];
    if (v[3]) begin
      c = ~ref_crc(plen);
      pbuf[plen] = c[7:0]; pbuf[plen+1] = c[15:8];
      plen += 2;
    end
    if (v[2]) pbuf[0] ^= 8'h01;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R8: reset state
    repeat (3) @(negedge clk);
    chk(res_valid == 0, "R8", "reset res_valid", 32'(res_valid), 0);
    chk(res_pass == 0, "R8", "reset res_pass", 32'(res_pass), 0);
    chk(res_crc == 16'hFFFF, "R8", "reset res_crc", 32'(res_crc), 32'hFFFF);
    rst_n = 1;
    @(negedge clk);
    // R7: ready always high
    chk(in_ready == 1, "R7", "in_ready", 32'(in_ready), 1);

    // table walk: R4 (good/corrupt), R5 (short, exact two), R2 (empty),
    // R6 (end merged), R9 (start merged)
    for (int k = 0; k < NVEC; k++) begin
      load_vec(VECS[k]);
      run_pkt(VECS[k][1], VECS[k][0], 1'b0,
              (k == 2 || k == 3 || k == 6) ? "R5" :
              (k == 4) ? "R6" : (k == 5 || k == 7) ? "R9" : "R4");
    end

    // R1: ASCII 1..9 check value
    plen = 9;
    for (int i = 0; i < 9; i++) pbuf[i] = 8'h31 + 8'(i);
    run_pkt(0, 0, 0, "R1");
    chk(res_crc == 16'h4B37, "R1", "check value", 32'(res_crc), 32'h4B37);

    // R7: idle beats with garbage data between bytes
    load_vec(VECS[0]);
    run_pkt(0, 0, 1'b1, "R7");
    chk(res_pass == 0 && res_valid == 0, "R7", "quiet after", 32'(res_pass), 0);

    // R2: abandoned bytes then a restart
    pkt_start = 1; @(negedge clk); pkt_start = 0;
    in_valid = 1; in_data = 8'hAA; @(negedge clk);
    in_data = 8'hBB; @(negedge clk); in_valid = 0;
    load_vec(VECS[4]);
    run_pkt(0, 0, 0, "R2");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule